// File: doc/BRIEF.md
# Touch Report Filter

This block reads the packed results of a resistive touch panel's conversion FIFO and turns each burst of samples into a single touch report. A burst starts when the conversion engine raises its interrupt line or when a start pulse arrives. The block then pops up to four words through a valid/ready interface and stops early if the FIFO runs empty.

Each word holds a 10-bit X field, a 10-bit Y field and a pen-level bit. The block inverts both coordinates. It averages the inverted coordinates of the two middle samples of a burst. The result is reported as a touch-down only if all four samples arrived and the last one still shows the pen on the panel. Any other outcome gives a touch-up report, which leaves the last reported coordinates unchanged.

If the overrun flag is high when a burst starts, the block discards the whole FIFO content and produces no report. Each report is marked by a one-clock strobe.

Top module: `touch_report_filter`

## Requirements
- R1: A burst starts when `irq_i` or `start_i` is high in a cycle in which the block is idle, and `fifo_ready_o` is high in the next cycle. A start seen while a burst is running has no effect.
- R2: In a normal burst at most four words are popped (a pop is a cycle with `fifo_valid_i` and `fifo_ready_o` both high). Popping ends early in the first cycle in which `fifo_valid_i` is low.
- R3: Word layout: bit 31 is the pen-level bit (1 = pen lifted), bits 25:16 hold raw X and bits 9:0 hold raw Y. Each coordinate is used as 1023 minus its raw value.
- R4: When exactly four words were popped and the fourth has bit 31 clear, the report is a touch-down (`rpt_touch_o` = 1). Its X is the truncated half of the sum of the inverted X values of the second and third popped words. Y is formed the same way from the Y values.
- R5: Every other completed normal burst, including one with no words at all, gives a touch-up report (`rpt_touch_o` = 0) with `rpt_x_o` and `rpt_y_o` unchanged.
- R6: If `ovr_i` is high in the cycle a burst starts, words are popped until `fifo_valid_i` is low and no report is produced.
- R7: `rpt_valid_o` is high for exactly one clock. It rises on the same clock edge that completes the last pop of the burst, or, for a burst that ends on an empty FIFO, on the edge at which the empty FIFO is seen.
- R8: After reset, `fifo_ready_o`, `rpt_valid_o`, `rpt_touch_o`, `rpt_x_o` and `rpt_y_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Burst request from the conversion engine |
| start_i | input | 1 | Burst request pulse from elsewhere |
| ovr_i | input | 1 | FIFO overrun status, sampled when a burst starts |
| fifo_valid_i | input | 1 | FIFO holds at least one word |
| fifo_data_i | input | 32 | Word at the FIFO head |
| fifo_ready_o | output | 1 | Pop request; a word is consumed when valid is also high |
| rpt_valid_o | output | 1 | One-clock report strobe |
| rpt_x_o | output | 10 | Reported X coordinate |
| rpt_y_o | output | 10 | Reported Y coordinate |
| rpt_touch_o | output | 1 | 1 = touch-down, 0 = touch-up |

## Verification
On every cycle the assertions check the following:
- the strobe is one clock long and directly follows a popping cycle;
- a touch-down always follows a pop of a word whose pen bit is clear;
- a touch-up leaves both coordinates as they were;
- a normal burst never pops more than four words;
- no report follows a drain.

The arithmetic cannot be shown by the assertions and is left to the bench scenarios: inversion, truncation at the coordinate extremes, which samples enter the average, and the number of words left in the FIFO after a burst. The same holds for ignoring a second start while a burst is running.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_COLLECT = 2'd1,
      ST_DRAIN   = 2'd2
   } burst_state_t;

   typedef struct packed {
      logic touch;
      logic valid;
   } report_flags_t;

endpackage

// File: rtl/tsf_word_unpack.sv
module tsf_word_unpack #(
   parameter int WORD_W    = 32,
   parameter int COORD_W   = 10,
   parameter int X_LSB     = 16,
   parameter int Y_LSB     = 0,
   parameter int PEN_BIT   = 31,
   parameter bit INVERT_EN = 1'b1
) (
   input  logic [WORD_W-1:0]  word_i,
   output logic [COORD_W-1:0] x_o,
   output logic [COORD_W-1:0] y_o,
   output logic               pen_up_o
);

   localparam logic [COORD_W-1:0] COORD_MAX = '1;

   if (X_LSB + COORD_W > WORD_W) begin : g_bad_x
      $error("X field does not fit in the word");
   end
   if (Y_LSB + COORD_W > WORD_W) begin : g_bad_y
      $error("Y field does not fit in the word");
   end
   if (PEN_BIT >= WORD_W) begin : g_bad_pen
      $error("pen bit lies outside the word");
   end

   logic [COORD_W-1:0] raw_x;
   logic [COORD_W-1:0] raw_y;

   assign raw_x    = word_i[X_LSB +: COORD_W];
   assign raw_y    = word_i[Y_LSB +: COORD_W];
   assign pen_up_o = word_i[PEN_BIT];

   if (INVERT_EN) begin : g_invert
      assign x_o = COORD_MAX - raw_x;
      assign y_o = COORD_MAX - raw_y;
   end else begin : g_direct
      assign x_o = raw_x;
      assign y_o = raw_y;
   end

endmodule

// File: rtl/tsf_burst_ctrl.sv
module tsf_burst_ctrl
   import tsf_pkg::*;
#(
   parameter int BURST_LEN = 4,
   parameter int CNT_W     = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             ovr_i,
   input  logic             fifo_valid_i,
   output logic             fifo_ready_o,
   output logic             pop_o,
   output logic [CNT_W-1:0] idx_o,
   output logic             launch_o,
   output logic             done_o,
   output logic             full_o,
   output logic             drain_o
);

   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BURST_LEN - 1);

   if (BURST_LEN < 3) begin : g_bad_len
      $error("a burst needs at least three samples");
   end

   burst_state_t       st_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               at_last;

   assign fifo_ready_o = (st_q != ST_IDLE);
   assign pop_o        = fifo_ready_o & fifo_valid_i;
   assign idx_o        = cnt_q;
   assign launch_o     = (st_q == ST_IDLE) & start_i;
   assign at_last      = (cnt_q == LAST_IDX);
   assign full_o       = (st_q == ST_COLLECT) & fifo_valid_i & at_last;
   assign done_o       = (st_q == ST_COLLECT) & (~fifo_valid_i | at_last);
   assign drain_o      = (st_q == ST_DRAIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               cnt_q <= '0;
               if (start_i) begin
                  st_q <= ovr_i ? ST_DRAIN : ST_COLLECT;
               end
            end
            ST_COLLECT: begin
               if (done_o) begin
                  st_q <= ST_IDLE;
               end else if (pop_o) begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_DRAIN: begin
               if (!fifo_valid_i) begin
                  st_q <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/tsf_pair_avg.sv
module tsf_pair_avg #(
   parameter int COORD_W    = 10,
   parameter int BURST_LEN  = 4,
   parameter int PICK_FIRST = 1,
   parameter int CNT_W      = 2,
   parameter int AXES       = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clear_i,
   input  logic                          pop_i,
   input  logic [CNT_W-1:0]              idx_i,
   input  logic [AXES-1:0][COORD_W-1:0]  coord_i,
   output logic [AXES-1:0][COORD_W-1:0]  avg_o
);

   localparam int SUM_W = COORD_W + 1;
   localparam logic [CNT_W-1:0] PICK_A = CNT_W'(PICK_FIRST);
   localparam logic [CNT_W-1:0] PICK_B = CNT_W'(PICK_FIRST + 1);

   if (PICK_FIRST < 0 || PICK_FIRST + 2 > BURST_LEN - 1) begin : g_bad_pick
      $error("averaged pair must finish before the last sample");
   end

   logic picked;
   assign picked = pop_i & ((idx_i == PICK_A) | (idx_i == PICK_B));

   for (genvar a = 0; a < AXES; a++) begin : g_axis
      logic [SUM_W-1:0] sum_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sum_q <= '0;
         end else if (clear_i) begin
            sum_q <= '0;
         end else if (picked) begin
            sum_q <= sum_q + SUM_W'(coord_i[a]);
         end
      end

      assign avg_o[a] = sum_q[SUM_W-1:1];
   end

endmodule

// File: rtl/touch_report_filter.sv
module touch_report_filter
   import tsf_pkg::*;
#(
   parameter int WORD_W     = 32,
   parameter int COORD_W    = 10,
   parameter int X_LSB      = 16,
   parameter int Y_LSB      = 0,
   parameter int PEN_BIT    = 31,
   parameter int BURST_LEN  = 4,
   parameter int PICK_FIRST = 1,
   parameter bit INVERT_EN  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               irq_i,
   input  logic               start_i,
   input  logic               ovr_i,
   input  logic               fifo_valid_i,
   input  logic [WORD_W-1:0]  fifo_data_i,
   output logic               fifo_ready_o,
   output logic               rpt_valid_o,
   output logic [COORD_W-1:0] rpt_x_o,
   output logic [COORD_W-1:0] rpt_y_o,
   output logic               rpt_touch_o
);

   localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
   localparam int AX_X  = 0;
   localparam int AX_Y  = 1;

   logic                         req;
   logic                         pop;
   logic [CNT_W-1:0]             idx;
   logic                         launch;
   logic                         done;
   logic                         full;
   logic                         drain_busy;
   logic [COORD_W-1:0]           cur_x;
   logic [COORD_W-1:0]           cur_y;
   logic                         cur_pen_up;
   logic [1:0][COORD_W-1:0]      cur_xy;
   logic [1:0][COORD_W-1:0]      avg_xy;
   report_flags_t                flags_q;
   logic [COORD_W-1:0]           x_q;
   logic [COORD_W-1:0]           y_q;

   assign req = irq_i | start_i;

   tsf_burst_ctrl #(
      .BURST_LEN (BURST_LEN),
      .CNT_W     (CNT_W)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (req),
      .ovr_i        (ovr_i),
      .fifo_valid_i (fifo_valid_i),
      .fifo_ready_o (fifo_ready_o),
      .pop_o        (pop),
      .idx_o        (idx),
      .launch_o     (launch),
      .done_o       (done),
      .full_o       (full),
      .drain_o      (drain_busy)
   );

   tsf_word_unpack #(
      .WORD_W    (WORD_W),
      .COORD_W   (COORD_W),
      .X_LSB     (X_LSB),
      .Y_LSB     (Y_LSB),
      .PEN_BIT   (PEN_BIT),
      .INVERT_EN (INVERT_EN)
   ) u_unpack (
      .word_i   (fifo_data_i),
      .x_o      (cur_x),
      .y_o      (cur_y),
      .pen_up_o (cur_pen_up)
   );

   assign cur_xy[AX_X] = cur_x;
   assign cur_xy[AX_Y] = cur_y;

   tsf_pair_avg #(
      .COORD_W    (COORD_W),
      .BURST_LEN  (BURST_LEN),
      .PICK_FIRST (PICK_FIRST),
      .CNT_W      (CNT_W),
      .AXES       (2)
   ) u_avg (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (launch),
      .pop_i   (pop & ~drain_busy),
      .idx_i   (idx),
      .coord_i (cur_xy),
      .avg_o   (avg_xy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         x_q     <= '0;
         y_q     <= '0;
      end else begin
         flags_q.valid <= done;
         if (done) begin
            if (full && !cur_pen_up) begin
               flags_q.touch <= 1'b1;
               x_q           <= avg_xy[AX_X];
               y_q           <= avg_xy[AX_Y];
            end else begin
               flags_q.touch <= 1'b0;
            end
         end
      end
   end

   assign rpt_valid_o = flags_q.valid;
   assign rpt_touch_o = flags_q.touch;
   assign rpt_x_o     = x_q;
   assign rpt_y_o     = y_q;

endmodule

// File: rtl/tsf_checker.sv
module tsf_checker #(
   parameter int COORD_W   = 10,
   parameter int BURST_LEN = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               fifo_valid_i,
   input logic               fifo_ready_o,
   input logic               pen_i,
   input logic               drain_i,
   input logic               rpt_valid_o,
   input logic               rpt_touch_o,
   input logic [COORD_W-1:0] rpt_x_o,
   input logic [COORD_W-1:0] rpt_y_o
);

   logic [7:0] pop_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pop_run <= '0;
      end else if (!fifo_ready_o) begin
         pop_run <= '0;
      end else if (fifo_valid_i && pop_run != 8'hff) begin
         pop_run <= pop_run + 1'b1;
      end
   end

   // R7
   strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_valid_o |=> !rpt_valid_o);

   // R7
   strobe_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_valid_o |-> ($past(fifo_ready_o) && !fifo_ready_o));

   // R4
   touch_needs_pen_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rpt_valid_o && rpt_touch_o) |-> $past(fifo_valid_i && fifo_ready_o && !pen_i));

   // R5
   hold_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rpt_valid_o && !rpt_touch_o) |-> ($stable(rpt_x_o) && $stable(rpt_y_o)));

   // R2
   burst_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_ready_o && !drain_i) |-> (32'(pop_run) < BURST_LEN));

   // R6
   no_report_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_valid_o |-> !$past(drain_i));

endmodule

bind touch_report_filter tsf_checker #(
   .COORD_W   (COORD_W),
   .BURST_LEN (BURST_LEN)
) u_tsf_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .fifo_valid_i (fifo_valid_i),
   .fifo_ready_o (fifo_ready_o),
   .pen_i        (fifo_data_i[PEN_BIT]),
   .drain_i      (drain_busy),
   .rpt_valid_o  (rpt_valid_o),
   .rpt_touch_o  (rpt_touch_o),
   .rpt_x_o      (rpt_x_o),
   .rpt_y_o      (rpt_y_o)
);

// File: tb/test_touch_report_filter.sv
module test_touch_report_filter;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_i = 1'b0;
   logic        start_i = 1'b0;
   logic        ovr_i = 1'b0;
   logic        fifo_valid = 1'b0;
   logic [31:0] fifo_data = '0;
   logic        fifo_ready_o;
   logic        rpt_valid_o;
   logic [9:0]  rpt_x_o;
   logic [9:0]  rpt_y_o;
   logic        rpt_touch_o;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit finished = 1'b0;

   logic [31:0] q[$];
   int n_pop, last_pop_cyc;
   int n_rpt, r_x, r_y, r_touch, r_cyc, run, max_run;
   int ready_after;

   always #(CLK_P/2) clk = ~clk;

   touch_report_filter i_touch_report_filter (
      .clk          (clk),
      .rst_n        (rst_n),
      .irq_i        (irq_i),
      .start_i      (start_i),
      .ovr_i        (ovr_i),
      .fifo_valid_i (fifo_valid),
      .fifo_data_i  (fifo_data),
      .fifo_ready_o (fifo_ready_o),
      .rpt_valid_o  (rpt_valid_o),
      .rpt_x_o      (rpt_x_o),
      .rpt_y_o      (rpt_y_o),
      .rpt_touch_o  (rpt_touch_o)
   );

   task automatic refresh();
      fifo_valid = (q.size() > 0);
      fifo_data  = (q.size() > 0) ? q[0] : 32'h0;
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // FIFO model: the pop decided mid-cycle takes effect just after the edge
   always begin
      @(negedge clk);
      if (fifo_ready_o && fifo_valid) begin
         @(posedge clk);
         #1;
         void'(q.pop_front());
         n_pop++;
         last_pop_cyc = cyc;
         refresh();
      end
   end

   always @(negedge clk) begin
      if (rpt_valid_o) begin
         n_rpt++;
         r_x = rpt_x_o;
         r_y = rpt_y_o;
         r_touch = rpt_touch_o;
         r_cyc = cyc;
         run++;
         if (run > max_run) max_run = run;
      end else begin
         run = 0;
      end
   end

   always @(posedge clk) begin
      if (cyc > 20000 && !finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mkword(input bit pen, input int x, input int y);
      return {pen, 5'b0, 10'(x), 6'b0, 10'(y)};
   endfunction

   task automatic flush();
      q.delete();
      refresh();
   endtask

   task automatic run_burst(input bit use_irq, input bit ovr, input bit again);
      n_pop = 0; n_rpt = 0; max_run = 0; run = 0;
      @(negedge clk);
      if (use_irq) irq_i = 1'b1; else start_i = 1'b1;
      ovr_i = ovr;
      @(negedge clk);
      irq_i = 1'b0; start_i = 1'b0; ovr_i = 1'b0;
      ready_after = fifo_ready_o;
      if (again) begin
         @(negedge clk);
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      repeat (14) @(negedge clk);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R8 ready", fifo_ready_o, 0);
      chk("R8 valid", rpt_valid_o, 0);
      chk("R8 x", rpt_x_o, 0);
      chk("R8 y", rpt_y_o, 0);
      chk("R8 touch", rpt_touch_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_full_touch();
      int xs[6] = '{100, 200, 300, 400, 50, 60};
      int ys[6] = '{10, 20, 30, 40, 5, 6};
      for (int i = 0; i < 6; i++) q.push_back(mkword(1'b0, xs[i], ys[i]));
      refresh();
      run_burst(1'b0, 1'b0, 1'b0);
      chk("R1 ready after start", ready_after, 1);
      chk("R7 one report", n_rpt, 1);
      chk("R4 touch", r_touch, 1);
      chk("R3 R4 x", r_x, ((1023 - 200) + (1023 - 300)) / 2);
      chk("R3 R4 y", r_y, ((1023 - 20) + (1023 - 30)) / 2);
      chk("R2 pops", n_pop, 4);
      chk("R2 left in fifo", q.size(), 2);
      chk("R7 strobe edge", r_cyc, last_pop_cyc);
      chk("R7 strobe width", max_run, 1);
      flush();
   endtask

   task automatic t_extremes();
      q.push_back(mkword(1'b0, 7, 7));
      q.push_back(mkword(1'b0, 0, 0));
      q.push_back(mkword(1'b0, 1023, 0));
      q.push_back(mkword(1'b0, 9, 9));
      refresh();
      run_burst(1'b0, 1'b0, 1'b0);
      chk("R4 touch extremes", r_touch, 1);
      chk("R3 x truncation", r_x, 511);
      chk("R3 y zero raw", r_y, 1023);
   endtask

   task automatic t_pen_lift();
      q.push_back(mkword(1'b0, 1, 1));
      q.push_back(mkword(1'b0, 2, 2));
      q.push_back(mkword(1'b0, 3, 3));
      q.push_back(mkword(1'b1, 4, 4));
      refresh();
      run_burst(1'b0, 1'b0, 1'b0);
      chk("R5 lift report", n_rpt, 1);
      chk("R5 lift touch", r_touch, 0);
      chk("R5 lift x kept", r_x, 511);
      chk("R5 lift y kept", r_y, 1023);
   endtask

   task automatic t_short();
      q.push_back(mkword(1'b0, 100, 100));
      q.push_back(mkword(1'b0, 200, 200));
      refresh();
      run_burst(1'b0, 1'b0, 1'b0);
      chk("R2 short pops", n_pop, 2);
      chk("R5 short report", n_rpt, 1);
      chk("R5 short touch", r_touch, 0);
      chk("R5 short x kept", r_x, 511);
      chk("R7 short strobe edge", r_cyc, last_pop_cyc + 1);
   endtask

   task automatic t_empty();
      flush();
      run_burst(1'b0, 1'b0, 1'b0);
      chk("R5 empty report", n_rpt, 1);
      chk("R5 empty touch", r_touch, 0);
      chk("R7 empty width", max_run, 1);
   endtask

   task automatic t_overrun();
      for (int i = 0; i < 6; i++) q.push_back(mkword(1'b0, 10 * i, 10 * i));
      refresh();
      run_burst(1'b1, 1'b1, 1'b0);
      chk("R6 no report", n_rpt, 0);
      chk("R6 drained", q.size(), 0);
      chk("R6 pops", n_pop, 6);
      chk("R6 outputs kept", rpt_x_o, 511);
   endtask

   task automatic t_busy_start();
      for (int i = 0; i < 8; i++) q.push_back(mkword(1'b0, 20 * i, 20 * i));
      refresh();
      run_burst(1'b1, 1'b0, 1'b1);
      chk("R1 busy one report", n_rpt, 1);
      chk("R1 busy left", q.size(), 4);
      chk("R1 irq touch", r_touch, 1);
      chk("R1 irq x", r_x, ((1023 - 20) + (1023 - 40)) / 2);
      flush();
   endtask

   initial begin
      refresh();
      t_reset();
      t_full_touch();
      t_extremes();
      t_pen_lift();
      t_short();
      t_empty();
      t_overrun();
      t_busy_start();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule